// File: doc/BRIEF.md
# Hysteretic Synchronous Gate Sequencer

This block sits between the comparators of a single-phase hysteretic buck regulator and its two gate drivers. The comparators are digital inputs sampled on the block clock. The core comparator decides which switch the loop wants on. The current-limit pair forms a blanking window that keeps the top switch off. The zero-crossing input stops the bottom switch from carrying reverse current. The block turns these decisions into enables for the top (high-side) and bottom (synchronous) switches.

Every turn-on of either switch waits through a programmable dead time with both switches off. Every top turn-on begins with a programmable weak-drive phase. Supply-undervoltage and thermal faults force both switches off. A latched over-voltage fault parks the bottom switch on. A one-cycle pulse marks each new current-limit event, so that an outside fault counter can count them.

Top module: `hyst_gate_seq`

## Requirements
- R1: Outside faults, `cmp_low`=1 requests the top switch and `cmp_low`=0 requests the bottom switch. The requested switch comes on once the dead time has elapsed.
- R2: Both enables stay low for at least max(`dead_cycles`,1) cycles before either enable rises from the idle or dead interval. The dead interval is counted from the first cycle in which both enables are low.
- R3: Each rise of `tg_en` comes with `tg_weak`=1. `tg_weak` stays high for max(`weak_cycles`,1) cycles and then falls while `tg_en` stays high. `tg_weak` is never high while `tg_en` is low.
- R4: When `zero_x`=1 is sampled, `bg_en` is low from the next cycle on. It stays low until the top switch is next requested.
- R5: When `ilim_hi`=1 is sampled, `tg_en` is low from the next cycle on. The top switch stays blocked until an edge samples `ilim_lo`=1 with `ilim_hi`=0.
- R6: `ilim_pulse` is high for exactly one cycle, in the cycle after each 0-to-1 change of `ilim_hi`. It also fires if `ilim_hi` is already 1 at the first edge after reset.
- R7: When `uvlo`=1 is sampled, both enables are low in the next cycle.
- R8: When `therm_fault`=1 is sampled, both enables are low in the next cycle. When `ovp_fault`=1 is sampled with `uvlo`=0 and `therm_fault`=0, the next cycle has `bg_en`=1 and `tg_en`=0.
- R9: After a fault input is removed, the bottom switch is turned off if it was forced on. Switching then resumes through a full dead interval.
- R10: `tg_en` and `bg_en` are never high in the same cycle.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_low | input | 1 | Core comparator: output below reference |
| ilim_hi | input | 1 | Sensed current above upper limit threshold |
| ilim_lo | input | 1 | Sensed current below lower limit threshold |
| zero_x | input | 1 | Sensed inductor current has reached zero |
| uvlo | input | 1 | Supply undervoltage lockout active |
| ovp_fault | input | 1 | Latched over-voltage fault |
| therm_fault | input | 1 | Thermal shutdown |
| dead_cycles | input | CW | Dead time in clocks (0 acts as 1) |
| weak_cycles | input | CW | Weak-drive phase length in clocks (0 acts as 1) |
| tg_en | output | 1 | Top switch gate enable |
| bg_en | output | 1 | Bottom switch gate enable |
| tg_weak | output | 1 | Top drive in weak phase |
| ilim_pulse | output | 1 | One-cycle current-limit event marker |

## Verification
The assertions are checked on every cycle. They cover gate exclusivity, the one-cycle forced response to undervoltage, thermal and over-voltage faults, the top-switch cut when the upper limit is seen, the bottom-switch cut at zero current, and the pairing of the weak flag with top turn-on. The following can only be shown by the bench scenarios, through a cycle-level reference model compared on every clock: the exact length of the dead and weak intervals under different parameter values, the holding of the zero-current latch until the next top request, the release of the current-limit window only at the lower threshold, and resumption after faults.

// File: rtl/hgs_pkg.sv
package hgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEAD  = 3'd1,
    ST_TWEAK = 3'd2,
    ST_TFULL = 3'd3,
    ST_BOT   = 3'd4,
    ST_FOFF  = 3'd5,
    ST_FBOT  = 3'd6
  } gate_st_t;

endpackage

// File: rtl/hgs_ilim_window.sv
module hgs_ilim_window (
  input  logic clk,
  input  logic rst_n,
  input  logic ilim_hi,
  input  logic ilim_lo,
  output logic blocked,
  output logic ilim_pulse
);

  logic blk_q, hi_q, pulse_q;
  logic pulse_d;

  // window opens on the upper threshold, closes only below the lower one
  always_comb begin
    blocked = ilim_hi | (blk_q & ~ilim_lo);
    pulse_d = ilim_hi & ~hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= 1'b0;
      hi_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      blk_q   <= blocked;
      hi_q    <= ilim_hi;
      pulse_q <= pulse_d;
    end
  end

  assign ilim_pulse = pulse_q;

endmodule

// File: rtl/hgs_zc_latch.sv
module hgs_zc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_x,
  input  logic top_req,
  output logic bot_allow
);

  logic zc_q, zc_d;

  // top request clears, zero crossing sets
  always_comb begin
    if (top_req) zc_d = 1'b0;
    else         zc_d = zc_q | zero_x;
    bot_allow = ~zc_q & ~zero_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_q <= 1'b0;
    else        zc_q <= zc_d;
  end

endmodule

// File: rtl/hgs_gate_fsm.sv
module hgs_gate_fsm
  import hgs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_top,
  input  logic          want_bot,
  input  logic          force_off,
  input  logic          force_bot,
  input  logic [CW-1:0] dead_cycles,
  input  logic [CW-1:0] weak_cycles,
  output logic          tg_en,
  output logic          bg_en,
  output logic          tg_weak
);

  localparam logic [CW-1:0] ONE = CW'(1);

  gate_st_t      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [CW-1:0] dead_lim, weak_lim;
  logic          dead_done, weak_done;

  always_comb begin
    dead_lim  = (dead_cycles == '0) ? ONE : dead_cycles;
    weak_lim  = (weak_cycles == '0) ? ONE : weak_cycles;
    dead_done = (cnt_q >= dead_lim - ONE);
    weak_done = (cnt_q >= weak_lim - ONE);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = '0;
    cnt_en = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (want_top || want_bot) st_d = ST_DEAD;
      end
      ST_DEAD: begin
        if (dead_done) begin
          if (want_top)      st_d = ST_TWEAK;
          else if (want_bot) st_d = ST_BOT;
          else               st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_TWEAK: begin
        if (!want_top)      st_d = ST_DEAD;
        else if (weak_done) st_d = ST_TFULL;
        else                cnt_d = cnt_q + ONE;
      end
      ST_TFULL: begin
        cnt_en = 1'b0;
        if (!want_top) begin
          st_d   = ST_DEAD;
          cnt_en = 1'b1;
        end
      end
      ST_BOT: begin
        cnt_en = 1'b0;
        if (want_top) begin
          st_d   = ST_DEAD;
          cnt_en = 1'b1;
        end else if (!want_bot) begin
          st_d = ST_IDLE;
        end
      end
      ST_FOFF: st_d = ST_IDLE;
      ST_FBOT: st_d = ST_DEAD;
      default: st_d = ST_IDLE;
    endcase
    if (force_off) begin
      st_d   = ST_FOFF;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (force_bot) begin
      st_d   = ST_FBOT;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    tg_en   = (st_q == ST_TWEAK) || (st_q == ST_TFULL);
    bg_en   = (st_q == ST_BOT) || (st_q == ST_FBOT);
    tg_weak = (st_q == ST_TWEAK);
  end

endmodule

// File: rtl/hyst_gate_seq.sv
module hyst_gate_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_low,
  input  logic          ilim_hi,
  input  logic          ilim_lo,
  input  logic          zero_x,
  input  logic          uvlo,
  input  logic          ovp_fault,
  input  logic          therm_fault,
  input  logic [CW-1:0] dead_cycles,
  input  logic [CW-1:0] weak_cycles,
  output logic          tg_en,
  output logic          bg_en,
  output logic          tg_weak,
  output logic          ilim_pulse
);

  logic blocked, bot_allow;
  logic want_top, want_bot, force_off, force_bot;

  hgs_ilim_window u_ilim (
    .clk        (clk),
    .rst_n      (rst_n),
    .ilim_hi    (ilim_hi),
    .ilim_lo    (ilim_lo),
    .blocked    (blocked),
    .ilim_pulse (ilim_pulse)
  );

  always_comb begin
    want_top  = cmp_low & ~blocked;
    want_bot  = ~want_top & bot_allow;
    force_off = uvlo | therm_fault;
    force_bot = ovp_fault & ~force_off;
  end

  hgs_zc_latch u_zc (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_x    (zero_x),
    .top_req   (want_top),
    .bot_allow (bot_allow)
  );

  hgs_gate_fsm #(.CW(CW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_top    (want_top),
    .want_bot    (want_bot),
    .force_off   (force_off),
    .force_bot   (force_bot),
    .dead_cycles (dead_cycles),
    .weak_cycles (weak_cycles),
    .tg_en       (tg_en),
    .bg_en       (bg_en),
    .tg_weak     (tg_weak)
  );

endmodule

// File: rtl/hyst_gate_seq_chk.sv
module hyst_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ilim_hi,
  input logic zero_x,
  input logic uvlo,
  input logic ovp_fault,
  input logic therm_fault,
  input logic tg_en,
  input logic bg_en,
  input logic tg_weak,
  input logic ilim_pulse
);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tg_en && bg_en));

  assert_uvlo_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!tg_en && !bg_en));

  assert_therm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    therm_fault |=> (!tg_en && !bg_en));

  assert_ovp_bot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_fault && !uvlo && !therm_fault) |=> (bg_en && !tg_en));

  assert_ilim_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_hi |=> !tg_en);

  assert_zero_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_x && !ovp_fault) |=> !bg_en);

  assert_weak_in_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tg_weak |-> tg_en);

  assert_weak_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tg_en) |-> tg_weak);

  assert_top_after_dead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tg_en) |-> $past(!bg_en));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_pulse |=> !ilim_pulse);

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_pulse |-> $past(ilim_hi));

endmodule

bind hyst_gate_seq hyst_gate_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ilim_hi     (ilim_hi),
  .zero_x      (zero_x),
  .uvlo        (uvlo),
  .ovp_fault   (ovp_fault),
  .therm_fault (therm_fault),
  .tg_en       (tg_en),
  .bg_en       (bg_en),
  .tg_weak     (tg_weak),
  .ilim_pulse  (ilim_pulse)
);

// File: tb/hyst_gate_seq_test.sv
`timescale 1ns/1ps
module hyst_gate_seq_test;

  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_low = 1'b0, ilim_hi = 1'b0, ilim_lo = 1'b0, zero_x = 1'b0;
  logic uvlo = 1'b0, ovp_fault = 1'b0, therm_fault = 1'b0;
  logic [CW-1:0] dead_cycles = 8'd3, weak_cycles = 8'd2;
  logic tg_en, bg_en, tg_weak, ilim_pulse;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  hyst_gate_seq #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_low(cmp_low), .ilim_hi(ilim_hi),
    .ilim_lo(ilim_lo), .zero_x(zero_x), .uvlo(uvlo), .ovp_fault(ovp_fault),
    .therm_fault(therm_fault), .dead_cycles(dead_cycles),
    .weak_cycles(weak_cycles), .tg_en(tg_en), .bg_en(bg_en),
    .tg_weak(tg_weak), .ilim_pulse(ilim_pulse)
  );

  // behavioural reference: phase 0 idle, 1 gap, 2 weak top, 3 full top,
  // 4 bottom, 5 forced off, 6 forced bottom
  int  ph = 0;
  int  elapsed = 0;
  bit  win = 0, zlatch = 0, hi_prev = 0, exp_pulse = 0;
  int  pulses_seen = 0, pulses_exp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; elapsed = 0; win = 0; zlatch = 0; hi_prev = 0; exp_pulse = 0;
    end else begin
      bit blk, up, dn;
      int gap, wk, nph;
      blk = ilim_hi || (win && !ilim_lo);
      up  = cmp_low && !blk;
      dn  = !up && !zlatch && !zero_x;
      gap = (dead_cycles == 0) ? 1 : int'(dead_cycles);
      wk  = (weak_cycles == 0) ? 1 : int'(weak_cycles);
      nph = ph;
      elapsed = elapsed + 1;
      case (ph)
        0: if (up || dn) begin nph = 1; elapsed = 0; end
        1: if (elapsed >= gap) begin
             nph = up ? 2 : (dn ? 4 : 0); elapsed = 0;
           end
        2: if (!up) begin nph = 1; elapsed = 0; end
           else if (elapsed >= wk) nph = 3;
        3: if (!up) begin nph = 1; elapsed = 0; end
        4: if (up) begin nph = 1; elapsed = 0; end
           else if (!dn) nph = 0;
        5: nph = 0;
        6: begin nph = 1; elapsed = 0; end
        default: nph = 0;
      endcase
      if (uvlo || therm_fault) begin nph = 5; elapsed = 0; end
      else if (ovp_fault)      begin nph = 6; elapsed = 0; end
      ph = nph;
      win = blk;
      zlatch = up ? 1'b0 : (zlatch || zero_x);
      exp_pulse = ilim_hi && !hi_prev;
      if (exp_pulse) pulses_exp++;
      hi_prev = ilim_hi;
    end
  end

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "tg_en", int'(tg_en), int'(ph == 2 || ph == 3));
      check(cur_req, "bg_en", int'(bg_en), int'(ph == 4 || ph == 6));
      check(cur_req, "tg_weak", int'(tg_weak), int'(ph == 2));
      check("R6", "ilim_pulse", int'(ilim_pulse), int'(exp_pulse));
      check("R10", "overlap", int'(tg_en && bg_en), 0);
      if (ilim_pulse) pulses_seen++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    step(2);
    at_neg();
    check("R11", "reset tg_en", int'(tg_en), 0);
    check("R11", "reset bg_en", int'(bg_en), 0);
    check("R11", "reset tg_weak", int'(tg_weak), 0);
    check("R11", "reset ilim_pulse", int'(ilim_pulse), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1, R2, R3: regulation with dead 3 and weak 2
    cur_req = "R1";
    cmp_low = 1'b1; step(12);
    at_neg(); check("R1", "top on while low", int'(tg_en), 1);
    @(posedge clk); #1;
    cmp_low = 1'b0; step(10);
    at_neg(); check("R1", "bottom on while high", int'(bg_en), 1);
    @(posedge clk); #1;
    cur_req = "R2";
    for (int k = 0; k < 6; k++) begin
      cmp_low = ~cmp_low; step(3 + k);
    end
    // R2, R3 with zero parameters acting as one
    cur_req = "R3";
    dead_cycles = 8'd0; weak_cycles = 8'd0;
    for (int k = 0; k < 6; k++) begin
      cmp_low = ~cmp_low; step(4);
    end
    dead_cycles = 8'd5; weak_cycles = 8'd4;
    cmp_low = 1'b1; step(3);
    cmp_low = 1'b0; step(12);
    cmp_low = 1'b1; step(14);

    // R4: zero crossing holds bottom off until next top request
    cur_req = "R4";
    dead_cycles = 8'd2; weak_cycles = 8'd1;
    cmp_low = 1'b0; step(6);
    zero_x = 1'b1; step(1); zero_x = 1'b0; step(8);
    at_neg(); check("R4", "bottom latched off", int'(bg_en), 0);
    @(posedge clk); #1;
    cmp_low = 1'b1; step(6);
    cmp_low = 1'b0; step(6);
    at_neg(); check("R4", "bottom back after top", int'(bg_en), 1);
    @(posedge clk); #1;

    // R5, R6: current-limit window
    cur_req = "R5";
    cmp_low = 1'b1; step(8);
    ilim_hi = 1'b1; step(3); ilim_hi = 1'b0; step(5);
    at_neg(); check("R5", "top blocked until lower", int'(tg_en), 0);
    @(posedge clk); #1;
    ilim_lo = 1'b1; step(1); ilim_lo = 1'b0; step(8);
    at_neg(); check("R5", "top back after lower", int'(tg_en), 1);
    @(posedge clk); #1;
    cur_req = "R6";
    ilim_hi = 1'b1; step(1); ilim_hi = 1'b0; step(1);
    ilim_hi = 1'b1; step(2); ilim_hi = 1'b0; ilim_lo = 1'b1; step(6);
    ilim_lo = 1'b0;

    // R7, R8, R9: forced states and recovery
    cur_req = "R7";
    uvlo = 1'b1; step(1);
    at_neg(); check("R7", "uvlo both off", int'(tg_en || bg_en), 0);
    @(posedge clk); #1;
    step(3); uvlo = 1'b0;
    cur_req = "R9"; step(8);
    cur_req = "R8";
    ovp_fault = 1'b1; step(1);
    at_neg(); check("R8", "ovp bottom on", int'(bg_en && !tg_en), 1);
    @(posedge clk); #1;
    step(3);
    therm_fault = 1'b1; step(1);
    at_neg(); check("R8", "thermal overrides ovp", int'(tg_en || bg_en), 0);
    @(posedge clk); #1;
    therm_fault = 1'b0; step(3);
    cur_req = "R9";
    ovp_fault = 1'b0; step(1);
    at_neg(); check("R9", "bottom released after ovp", int'(bg_en), 0);
    @(posedge clk); #1;
    step(10);

    // mixed traffic
    cur_req = "R1";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) cmp_low = ~cmp_low;
      ilim_hi     = ($urandom_range(0, 99) < 4);
      ilim_lo     = ($urandom_range(0, 99) < 20);
      zero_x      = ($urandom_range(0, 99) < 5);
      uvlo        = ($urandom_range(0, 999) < 8);
      therm_fault = ($urandom_range(0, 999) < 5);
      ovp_fault   = ($urandom_range(0, 999) < 10);
      if (k % 500 == 0) begin
        dead_cycles = CW'($urandom_range(0, 4));
        weak_cycles = CW'($urandom_range(0, 3));
      end
      step(1);
    end
    uvlo = 1'b0; therm_fault = 1'b0; ovp_fault = 1'b0; ilim_hi = 1'b0;
    step(4);

    at_neg();
    check("R6", "pulse count", pulses_seen, pulses_exp);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule